// File: doc/BRIEF.md
# Frame Clock Rate Detector and Activity Monitor

This block sits in the bit-clock domain of a four-channel time-slotted voice interface. It works out from the frame-separation strobe whether the bit clock runs at 256 or 512 cycles per 8 kHz frame. It reports the result as a 32/64 slot select, together with a flag that says whether the last measured frame was one of the two legal lengths.

It also watches for inputs that have gone quiet. Each channel's transmit frame sync has its own idle timer, and the separation strobe has one as well. An input that stays low for four frame periods (500 µs) raises a standby flag for that channel. For the strobe, it raises the device-wide powerdown flag. The timeout in bit-clock cycles follows the detected rate. The first high sample on the quiet input clears its flag again.

Top module: `frame_clock_supervisor`

## Requirements
- R1: While reset is held and just after it, slot64_sel is 0 (32 slots), rate_valid is 0, every chan_standby bit is 0 and powerdown is 0.
- R2: Rising edges of sep_strobe are measured rising edge to rising edge, with the strobe sampled on each clock edge. A spacing of 256 cycles sets slot64_sel to 0 and rate_valid to 1. A spacing of 512 cycles sets slot64_sel to 1 and rate_valid to 1. Both take effect on the clock edge that samples the second rising edge.
- R3: Any other rise-to-rise spacing clears rate_valid and leaves slot64_sel unchanged. slot64_sel never changes while rate_valid ends up 0.
- R4: The first rising edge of sep_strobe after reset only starts a measurement and makes no decision.
- R5: chan_standby[i] is set once fsync[i] has been sampled low on N consecutive clock edges. N is 1024 while slot64_sel is 0 and 2048 while it is 1.
- R6: A standby flag clears on the clock edge that first samples its fsync input high.
- R7: powerdown is set once sep_strobe has been sampled low on N consecutive edges, with the same N as R5. It clears on the edge that first samples the strobe high.
- R8: All chan_standby bits read 1 while powerdown is 1.
- R9: The width of the strobe's high pulse does not affect the rate decision; only its rising edges count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sep_strobe | input | 1 | 8 kHz frame-separation strobe |
| fsync | input | 4 | Per-channel transmit frame syncs |
| slot64_sel | output | 1 | 0 = 32 slots per frame, 1 = 64 slots per frame |
| rate_valid | output | 1 | Last measured frame had a legal length |
| chan_standby | output | 4 | Per-channel idle flags |
| powerdown | output | 1 | Separation strobe lost |

## Verification
Assertions check the following on every cycle. The slot select moves only when the rate flag ends high. The rate flag rises only after a sampled rising edge of the strobe. The first edge after reset never validates a rate. Every idle flag drops right after a high sample and rises only after a low one. Only the bench's scenarios can show the rest: the exact timeout count at each rate, the timeout doubling after the switch to 64 slots, rejection of an odd frame length while the old selection is kept, wide strobe pulses, and every standby bit being forced during powerdown. For these, a behavioural model is compared against the outputs on every clock.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic {
        SLOTS_32 = 1'b0,
        SLOTS_64 = 1'b1
    } slot_mode_e;
endpackage

// File: rtl/fcs_rate_detect.sv
module fcs_rate_detect
    import fcs_pkg::*;
#(
    parameter int SHORT_FRAME = 256,
    parameter int LONG_FRAME  = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_in,
    output slot_mode_e mode_o,
    output logic       valid_o
);
    localparam int CW = $clog2(LONG_FRAME) + 1;
    localparam logic [CW:0] SHORT_W = (CW+1)'(SHORT_FRAME);
    localparam logic [CW:0] LONG_W  = (CW+1)'(LONG_FRAME);

    typedef struct packed {
        logic          prev;
        logic          seen;
        logic [CW-1:0] cnt;
        slot_mode_e    mode;
        logic          valid;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      rise;
    logic [CW:0] meas;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe_in;
        rise      = strobe_in & ~st_q.prev;
        meas      = {1'b0, st_q.cnt} + (CW+1)'(1);
        if (rise) begin
            st_d.cnt  = '0;
            st_d.seen = 1'b1;
            if (st_q.seen) begin
                if (meas == SHORT_W) begin
                    st_d.mode  = SLOTS_32;
                    st_d.valid = 1'b1;
                end else if (meas == LONG_W) begin
                    st_d.mode  = SLOTS_64;
                    st_d.valid = 1'b1;
                end else begin
                    st_d.valid = 1'b0;
                end
            end
        end else if (st_q.cnt != {CW{1'b1}}) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b0, seen: 1'b0, cnt: '0, mode: SLOTS_32, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign valid_o = st_q.valid;

    assert_mode_moves_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != $past(st_q.mode)) |-> st_q.valid);

    assert_valid_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> $past(rise));

    assert_first_edge_no_decision_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !st_q.seen) |=> !st_q.valid);
endmodule

// File: rtl/fcs_idle_timer.sv
module fcs_idle_timer #(
    parameter int LIMIT_SHORT = 1024,
    parameter int LIMIT_LONG  = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic long_mode,
    output logic flag_o
);
    localparam int TW = $clog2(LIMIT_LONG) + 1;
    localparam logic [TW:0] LIM_S = (TW+1)'(LIMIT_SHORT);
    localparam logic [TW:0] LIM_L = (TW+1)'(LIMIT_LONG);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          flag;
    } it_state_t;

    it_state_t   st_d, st_q;
    logic [TW:0] cnt_inc;
    logic [TW:0] limit;

    always_comb begin
        st_d    = st_q;
        limit   = long_mode ? LIM_L : LIM_S;
        cnt_inc = {1'b0, st_q.cnt} + (TW+1)'(1);
        if (level_in) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else begin
            if (st_q.cnt != {TW{1'b1}}) begin
                st_d.cnt = cnt_inc[TW-1:0];
            end
            st_d.flag = (cnt_inc >= limit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    assert_clear_on_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level_in |=> !st_q.flag);

    assert_set_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> !$past(level_in));
endmodule

// File: rtl/frame_clock_supervisor.sv
module frame_clock_supervisor
    import fcs_pkg::*;
#(
    parameter int NUM_CH         = 4,
    parameter int SHORT_FRAME    = 256,
    parameter int LONG_FRAME     = 512,
    parameter int TIMEOUT_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sep_strobe,
    input  logic [NUM_CH-1:0] fsync,
    output logic              slot64_sel,
    output logic              rate_valid,
    output logic [NUM_CH-1:0] chan_standby,
    output logic              powerdown
);
    localparam int LIM_SHORT = TIMEOUT_FRAMES * SHORT_FRAME;
    localparam int LIM_LONG  = TIMEOUT_FRAMES * LONG_FRAME;

    slot_mode_e        mode;
    logic              long_mode;
    logic [NUM_CH-1:0] ch_idle;
    logic              sep_idle;

    fcs_rate_detect #(
        .SHORT_FRAME(SHORT_FRAME),
        .LONG_FRAME (LONG_FRAME)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_in(sep_strobe),
        .mode_o   (mode),
        .valid_o  (rate_valid)
    );

    assign long_mode  = (mode == SLOTS_64);
    assign slot64_sel = long_mode;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        fcs_idle_timer #(
            .LIMIT_SHORT(LIM_SHORT),
            .LIMIT_LONG (LIM_LONG)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (fsync[g]),
            .long_mode(long_mode),
            .flag_o   (ch_idle[g])
        );
    end

    fcs_idle_timer #(
        .LIMIT_SHORT(LIM_SHORT),
        .LIMIT_LONG (LIM_LONG)
    ) u_sep_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (sep_strobe),
        .long_mode(long_mode),
        .flag_o   (sep_idle)
    );

    assign powerdown    = sep_idle;
    assign chan_standby = ch_idle | {NUM_CH{sep_idle}};

    assert_pd_clears_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sep_strobe |=> !powerdown);
endmodule

// File: tb/sim_frame_clock_supervisor.sv
module sim_frame_clock_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sep_strobe = 1'b0;
    logic [3:0] fsync = '0;
    logic       slot64_sel, rate_valid, powerdown;
    logic [3:0] chan_standby;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    frame_clock_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .sep_strobe(sep_strobe), .fsync(fsync),
        .slot64_sel(slot64_sel), .rate_valid(rate_valid),
        .chan_standby(chan_standby), .powerdown(powerdown)
    );

    // stimulus generator: frame phase counter
    int       period_cfg = 256;
    int       sep_w = 1;
    bit       sep_en = 1;
    bit [3:0] fs_en = 4'hF;
    int       ph = 0;

    always @(negedge clk) begin
        if (ph + 1 >= period_cfg) ph = 0; else ph = ph + 1;
        sep_strobe <= sep_en && (ph < sep_w);
        for (int i = 0; i < 4; i++) fsync[i] <= fs_en[i] && (ph == (i + 1) * 16);
    end

    // behavioural reference model
    int cyc, last_rise, run[5];
    bit seen, m_prev, m_sel, m_valid;
    bit m_flag[5];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc = 0; last_rise = 0; seen = 0; m_prev = 0; m_sel = 0; m_valid = 0;
            for (int i = 0; i < 5; i++) begin run[i] = 0; m_flag[i] = 0; end
        end else begin
            int lim;
            bit lv;
            cyc = cyc + 1;
            lim = m_sel ? 2048 : 1024;
            for (int i = 0; i < 5; i++) begin
                lv = (i < 4) ? fsync[i] : sep_strobe;
                if (lv) run[i] = 0;
                else if (run[i] < 100000) run[i] = run[i] + 1;
                m_flag[i] = (run[i] >= lim);
            end
            if (sep_strobe && !m_prev) begin
                if (seen) begin
                    if (cyc - last_rise == 256) begin m_sel = 0; m_valid = 1; end
                    else if (cyc - last_rise == 512) begin m_sel = 1; m_valid = 1; end
                    else m_valid = 0;
                end
                last_rise = cyc;
                seen = 1;
            end
            m_prev = sep_strobe;
        end
    end

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] exp_sb;
            for (int i = 0; i < 4; i++) exp_sb[i] = m_flag[i] | m_flag[4]; // R8
            chk("R2 slot select", {3'b0, slot64_sel}, {3'b0, m_sel});
            chk("R3 rate valid", {3'b0, rate_valid}, {3'b0, m_valid});
            chk("R5 standby", chan_standby, exp_sb);
            chk("R7 powerdown", {3'b0, powerdown}, {3'b0, m_flag[4]});
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        // R1: reset state
        chk("R1 sel", {3'b0, slot64_sel}, 4'h0);
        chk("R1 valid", {3'b0, rate_valid}, 4'h0);
        chk("R1 standby", chan_standby, 4'h0);
        chk("R1 powerdown", {3'b0, powerdown}, 4'h0);
        rst_n = 1'b1;
        wait_cyc(100);
        chk("R4 no decision on first edge", {3'b0, rate_valid}, 4'h0);
        wait_cyc(1000);
        chk("R2 256-cycle frame valid", {3'b0, rate_valid}, 4'h1);
        chk("R2 256-cycle frame sel", {3'b0, slot64_sel}, 4'h0);
        // R5/R6 at 32 slots
        fs_en = 4'b1011;
        wait_cyc(1100);
        chk("R5 channel 2 idle", chan_standby, 4'b0100);
        fs_en = 4'hF;
        wait_cyc(300);
        chk("R6 channel 2 resumed", chan_standby, 4'h0);
        // 64 slots
        period_cfg = 512;
        wait_cyc(1600);
        chk("R2 512-cycle frame valid", {3'b0, rate_valid}, 4'h1);
        chk("R2 512-cycle frame sel", {3'b0, slot64_sel}, 4'h1);
        fs_en = 4'b1110;
        wait_cyc(1500);
        chk("R5 longer timeout at 64 slots", chan_standby, 4'h0);
        wait_cyc(700);
        chk("R5 channel 0 idle at 64 slots", chan_standby, 4'b0001);
        fs_en = 4'hF;
        wait_cyc(600);
        chk("R6 channel 0 resumed", chan_standby, 4'h0);
        // R9 wide strobe
        sep_w = 40;
        wait_cyc(1100);
        chk("R9 wide strobe valid", {3'b0, rate_valid}, 4'h1);
        chk("R9 wide strobe sel", {3'b0, slot64_sel}, 4'h1);
        sep_w = 1;
        // R3 illegal frame length
        period_cfg = 300;
        wait_cyc(900);
        chk("R3 odd frame invalid", {3'b0, rate_valid}, 4'h0);
        chk("R3 odd frame keeps sel", {3'b0, slot64_sel}, 4'h1);
        period_cfg = 256;
        wait_cyc(800);
        chk("R2 back to 32 slots", {rate_valid, slot64_sel, 2'b0}, 4'b1000);
        // R7/R8 strobe loss
        sep_en = 0;
        wait_cyc(1100);
        chk("R7 powerdown set", {3'b0, powerdown}, 4'h1);
        chk("R8 all standby in powerdown", chan_standby, 4'hF);
        sep_en = 1;
        wait_cyc(300);
        chk("R7 powerdown cleared", {3'b0, powerdown}, 4'h0);
        chk("R8 standby released", chan_standby, 4'h0);
        wait_cyc(10);
        finish_run();
    end
endmodule